// File: doc/BRIEF.md
# Halfword External Bus Cycle Sequencer

This block sits between a 32-bit core and a 16-bit external bus that reaches a 16 MB byte address space. It turns each core request into one or more halfword transfers: a single transfer for byte and halfword accesses, two transfers for a word, and a run of consecutive transfers for a cache-line read. Every transfer opens with a one-cycle active-low start strobe and closes in the cycle a ready input is sampled high. The block also drives the halfword address, two active-low byte-lane strobes, a write indicator, a space select (user memory or I/O) and a status line that tells instruction fetches from operand accesses. Requests whose address falls in the on-chip region are taken from the core but start no external cycle; another unit serves them.

The same pins serve a second role. When an external master asks for the bus with a hold request, the sequencer finishes any transfer or burst it has in flight, releases every pin it drives, and only then raises hold acknowledge. While held, the address, strobes, space select, write indicator and data pins are inputs, and the block forwards each access the external master starts into a synchronous on-chip memory port. Pins are driven by a per-group output-enable rather than by tri-state logic inside the block, so the pad ring does the actual tri-stating.

Top module: `xbus_cycle_unit`

## Requirements
- R1: After a synchronous reset the start strobe is high, the pin group is driven (pins_oe_o high), hold acknowledge is low, data_oe_o is low, rsp_valid_o is low and req_ready_o is high.
- R2: Every external transfer begins with bs_n_o low for exactly one cycle, followed by bs_n_o high until ready_i is sampled high; each transfer of a multi-transfer access gets its own start strobe, beginning the cycle after the previous transfer's ready.
- R3: addr_o carries byte-address bits [23:1]. Byte and halfword accesses use the request address; word and line accesses start at the word-aligned halfword and step up by one halfword per transfer (upper halfword first).
- R4: bc_n_o[1] strobes data bits [15:8] (the even, more significant byte) and bc_n_o[0] strobes bits [7:0]. Both are low for every read. For a byte write only the lane chosen by address bit 0 is low (0 selects bc_n_o[1]); halfword and word writes assert both.
- R5: One response pulse per byte or halfword access and one per word: a byte read returns the lane chosen by address bit 0 zero-extended, a halfword read returns data_i zero-extended, and a word returns {first transfer, second transfer}. req_size_i encodes 0 byte, 1 halfword, 2 word, 3 line read of LINE_WORDS words.
- R6: st_o is low for fetch requests and high for operand requests; sid_o is low for user space and high for I/O space, both held for the whole access.
- R7: A request whose address bits [23:20] equal INT_REGION (default 4'hF) is accepted but produces no start strobe and no response.
- R8: A hold request is acknowledged only when no access is in flight; pins_oe_o falls one cycle before hold_ack_o rises and stays low while hold_ack_o is high.
- R9: When hold_req_i drops, hold_ack_o falls at the next edge while pins stay released for that cycle; pins_oe_o rises one cycle later.
- R10: While held, a sampled low bs_n_i with sid_i low produces a memory request in the next cycle with write = wr_i, byte enables = inverted bc_n_i, and the halfword address taken from addr_i with its four top bits ignored; with sid_i high no request is made.
- R11: For a held read, data_o carries the memory read data with data_oe_o high for one cycle, starting two cycles after the memory request.
- R12: wr_o is high for write transfers and low for reads; data_oe_o is high during write transfers only, and data_o then carries the written byte on both lanes for a byte, the low halfword for a halfword, or the upper then lower halfword for a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Core request valid |
| req_ready_o | output | 1 | Request accepted this cycle when valid |
| req_write_i | input | 1 | Request is a write |
| req_fetch_i | input | 1 | Request is an instruction fetch |
| req_io_i | input | 1 | Request targets I/O space |
| req_size_i | input | 2 | 0 byte, 1 halfword, 2 word, 3 line read |
| req_addr_i | input | ADDR_W | Byte address |
| req_wdata_i | input | 32 | Write data, right-aligned |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_data_o | output | 32 | Read data returned to the core |
| ready_i | input | 1 | Transfer completes when sampled high |
| hold_req_i | input | 1 | External master asks for the bus |
| hold_ack_o | output | 1 | Bus released to the external master |
| pins_oe_o | output | 1 | Drive enable for address, strobes, sid, start, status, write |
| addr_o | output | ADDR_W-1 | Halfword address out |
| addr_i | input | ADDR_W-1 | Halfword address in (hold) |
| bc_n_o | output | 2 | Byte strobes out, [1] upper lane |
| bc_n_i | input | 2 | Byte strobes in (hold) |
| sid_o | output | 1 | Space select out |
| sid_i | input | 1 | Space select in (hold) |
| bs_n_o | output | 1 | Start strobe out |
| bs_n_i | input | 1 | Start strobe in (hold) |
| st_o | output | 1 | Fetch/operand status |
| wr_o | output | 1 | Write indicator out |
| wr_i | input | 1 | Write indicator in (hold) |
| data_o | output | 16 | Data bus out |
| data_i | input | 16 | Data bus in |
| data_oe_o | output | 1 | Data bus drive enable |
| mem_req_o | output | 1 | On-chip memory request |
| mem_we_o | output | 1 | On-chip memory write |
| mem_be_o | output | 2 | On-chip memory byte enables, [1] upper |
| mem_addr_o | output | ADDR_W-5 | On-chip memory halfword address |
| mem_wdata_o | output | 16 | On-chip memory write data |
| mem_rdata_i | input | 16 | On-chip memory read data, one cycle after request |

## Verification
The assertions watch, on every cycle, that a start strobe not met by ready is followed by a quiet strobe, that reads always assert both lanes, that data is driven by the master side only for writes, and the ordering of pin release against hold acknowledge on entry and on exit, plus the suppression of held accesses with I/O space selected. What the bench scenarios alone can show is the content of each transfer: the ascending halfword addresses, lane selection by address bit 0, the word assembly order, the fetch and space lines, the response pulse timing under wait states, the silence of on-chip region requests, the deferral of a hold request behind a running burst, and the two-cycle latency of held reads.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_LINE = 2'd3
  } xfer_size_e;

  typedef enum logic [1:0] {
    S_IDLE   = 2'd0,
    S_XFER   = 2'd1,
    S_HENTER = 2'd2,
    S_HOLD   = 2'd3
  } bus_state_e;
endpackage

// File: rtl/xbus_lane_unit.sv
// Byte-lane steering: strobes and write data for one transfer, and the
// lane extraction for single-transfer reads. Purely combinational.
module xbus_lane_unit
  import xbus_pkg::*;
(
  input  logic [1:0]  size_i,
  input  logic        write_i,
  input  logic        addr0_i,
  input  logic        odd_beat_i,
  input  logic [31:0] wdata_i,
  input  logic [15:0] rdata_i,
  output logic        wr_o,
  output logic [1:0]  bc_n_o,
  output logic [15:0] wdata_o,
  output logic [31:0] rlane_o
);
  xfer_size_e sz;

  always_comb begin
    sz   = xfer_size_e'(size_i);
    // line bursts are read-only
    wr_o = write_i && (sz != SZ_LINE);
    if (wr_o && sz == SZ_BYTE) bc_n_o = addr0_i ? 2'b10 : 2'b01;
    else                       bc_n_o = 2'b00;
    case (sz)
      SZ_BYTE: wdata_o = {wdata_i[7:0], wdata_i[7:0]};
      SZ_HALF: wdata_o = wdata_i[15:0];
      default: wdata_o = odd_beat_i ? wdata_i[15:0] : wdata_i[31:16];
    endcase
    if (sz == SZ_BYTE) rlane_o = {24'd0, addr0_i ? rdata_i[7:0] : rdata_i[15:8]};
    else               rlane_o = {16'd0, rdata_i};
  end
endmodule

// File: rtl/xbus_hold_port.sv
// While the bus is held, turns external-master cycles into requests on
// the synchronous on-chip memory port and returns read data to the pins.
module xbus_hold_port #(
  parameter int MEM_AW = 19
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic              bs_n_i,
  input  logic              sid_i,
  input  logic              wr_i,
  input  logic [1:0]        bc_n_i,
  input  logic [MEM_AW-1:0] addr_i,
  input  logic [15:0]       data_i,
  input  logic [15:0]       mem_rdata_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [1:0]        mem_be_o,
  output logic [MEM_AW-1:0] mem_addr_o,
  output logic [15:0]       mem_wdata_o,
  output logic              rd_drive_o,
  output logic [15:0]       rd_data_o
);
  logic hit;
  logic rd_p1, rd_p2;

  assign hit = en_i && !bs_n_i && !sid_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req_o   <= 1'b0;
      mem_we_o    <= 1'b0;
      mem_be_o    <= 2'b00;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
      rd_p1       <= 1'b0;
      rd_p2       <= 1'b0;
      rd_drive_o  <= 1'b0;
      rd_data_o   <= '0;
    end else begin
      mem_req_o   <= hit;
      mem_we_o    <= wr_i;
      mem_be_o    <= ~bc_n_i;
      mem_addr_o  <= addr_i;
      mem_wdata_o <= data_i;
      rd_p1       <= hit && !wr_i;   // request on the memory port
      rd_p2       <= rd_p1;          // memory data now valid
      rd_drive_o  <= rd_p2;
      if (rd_p2) rd_data_o <= mem_rdata_i;
    end
  end
endmodule

// File: rtl/xbus_cycle_unit.sv
module xbus_cycle_unit
  import xbus_pkg::*;
#(
  parameter int         ADDR_W     = 24,
  parameter int         LINE_WORDS = 2,
  parameter logic [3:0] INT_REGION = 4'hF,
  localparam int        HA_W       = ADDR_W - 1,
  localparam int        MEM_AW     = HA_W - 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic              req_fetch_i,
  input  logic              req_io_i,
  input  logic [1:0]        req_size_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [31:0]       req_wdata_i,
  output logic              rsp_valid_o,
  output logic [31:0]       rsp_data_o,
  input  logic              ready_i,
  input  logic              hold_req_i,
  output logic              hold_ack_o,
  output logic              pins_oe_o,
  output logic [HA_W-1:0]   addr_o,
  input  logic [HA_W-1:0]   addr_i,
  output logic [1:0]        bc_n_o,
  input  logic [1:0]        bc_n_i,
  output logic              sid_o,
  input  logic              sid_i,
  output logic              bs_n_o,
  input  logic              bs_n_i,
  output logic              st_o,
  output logic              wr_o,
  input  logic              wr_i,
  output logic [15:0]       data_o,
  input  logic [15:0]       data_i,
  output logic              data_oe_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [1:0]        mem_be_o,
  output logic [MEM_AW-1:0] mem_addr_o,
  output logic [15:0]       mem_wdata_o,
  input  logic [15:0]       mem_rdata_i
);
  localparam int MAX_BEATS = 2 * LINE_WORDS;
  localparam int BEAT_W    = $clog2(MAX_BEATS) + 1;

  bus_state_e        st_q;
  logic [BEAT_W-1:0] beat_q, nbeats_q, nbeats_d;
  logic              last_q;
  logic [HA_W-1:0]   haddr_q, l_haddr;
  logic [1:0]        size_q, l_size;
  logic              write_q, addr0_q, l_write, l_addr0, l_odd;
  logic [31:0]       wdata_q, l_wdata;
  logic [15:0]       acc_q, wdat_q;
  logic              wroe_q;
  logic              accept, is_int, ext_accept, xfer_done, more, launch;
  logic              ln_wr;
  logic [1:0]        ln_bc;
  logic [15:0]       ln_wd;
  logic [31:0]       ln_rl;
  logic              hp_drive;
  logic [15:0]       hp_data;

  // request decode and launch selection
  always_comb begin
    req_ready_o = (st_q == S_IDLE) && !hold_req_i;
    accept      = req_ready_o && req_valid_i;
    is_int      = req_addr_i[ADDR_W-1 -: 4] == INT_REGION;
    ext_accept  = accept && !is_int;
    xfer_done   = (st_q == S_XFER) && ready_i;
    more        = xfer_done && !last_q;
    launch      = ext_accept || more;
    case (xfer_size_e'(req_size_i))
      SZ_WORD: nbeats_d = BEAT_W'(2);
      SZ_LINE: nbeats_d = BEAT_W'(MAX_BEATS);
      default: nbeats_d = BEAT_W'(1);
    endcase
    if (ext_accept) begin
      l_size  = req_size_i;
      l_write = req_write_i;
      l_addr0 = req_addr_i[0];
      l_odd   = 1'b0;
      l_wdata = req_wdata_i;
      l_haddr = req_size_i[1] ? {req_addr_i[ADDR_W-1:2], 1'b0} : req_addr_i[ADDR_W-1:1];
    end else begin
      l_size  = size_q;
      l_write = write_q;
      l_addr0 = addr0_q;
      l_odd   = !beat_q[0];
      l_wdata = wdata_q;
      l_haddr = haddr_q + HA_W'(1);
    end
  end

  xbus_lane_unit u_lane (
    .size_i     (l_size),
    .write_i    (l_write),
    .addr0_i    (l_addr0),
    .odd_beat_i (l_odd),
    .wdata_i    (l_wdata),
    .rdata_i    (data_i),
    .wr_o       (ln_wr),
    .bc_n_o     (ln_bc),
    .wdata_o    (ln_wd),
    .rlane_o    (ln_rl)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= S_IDLE;
      beat_q      <= '0;
      nbeats_q    <= BEAT_W'(1);
      last_q      <= 1'b1;
      haddr_q     <= '0;
      size_q      <= 2'd0;
      write_q     <= 1'b0;
      addr0_q     <= 1'b0;
      wdata_q     <= '0;
      acc_q       <= '0;
      wdat_q      <= '0;
      wroe_q      <= 1'b0;
      rsp_valid_o <= 1'b0;
      rsp_data_o  <= '0;
      hold_ack_o  <= 1'b0;
      pins_oe_o   <= 1'b1;
      addr_o      <= '0;
      bc_n_o      <= 2'b11;
      sid_o       <= 1'b0;
      bs_n_o      <= 1'b1;
      st_o        <= 1'b1;
      wr_o        <= 1'b0;
    end else begin
      bs_n_o      <= 1'b1;
      rsp_valid_o <= 1'b0;

      if (launch) begin
        haddr_q <= l_haddr;
        addr_o  <= l_haddr;
        bc_n_o  <= ln_bc;
        wr_o    <= ln_wr;
        wdat_q  <= ln_wd;
        wroe_q  <= ln_wr;
        bs_n_o  <= 1'b0;
      end

      if (ext_accept) begin
        st_q     <= S_XFER;
        size_q   <= req_size_i;
        write_q  <= req_write_i;
        addr0_q  <= req_addr_i[0];
        wdata_q  <= req_wdata_i;
        sid_o    <= req_io_i;
        st_o     <= !req_fetch_i;
        beat_q   <= '0;
        nbeats_q <= nbeats_d;
        last_q   <= nbeats_d == BEAT_W'(1);
      end

      if (more) begin
        beat_q <= beat_q + BEAT_W'(1);
        last_q <= (beat_q + BEAT_W'(2)) == nbeats_q;
      end

      if (xfer_done) begin
        if (size_q[1]) begin
          if (!beat_q[0]) acc_q <= data_i;
          else begin
            rsp_valid_o <= 1'b1;
            rsp_data_o  <= {acc_q, data_i};
          end
        end else begin
          rsp_valid_o <= 1'b1;
          rsp_data_o  <= ln_rl;
        end
        if (last_q) begin
          st_q   <= S_IDLE;
          wroe_q <= 1'b0;
        end
      end

      // hold handover: release, then acknowledge; drop, then drive again
      case (st_q)
        S_IDLE: begin
          if (hold_req_i) begin
            pins_oe_o <= 1'b0;
            st_q      <= S_HENTER;
          end else begin
            pins_oe_o <= 1'b1;
          end
        end
        S_HENTER: begin
          hold_ack_o <= 1'b1;
          st_q       <= S_HOLD;
        end
        S_HOLD: begin
          if (!hold_req_i) begin
            hold_ack_o <= 1'b0;
            st_q       <= S_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  xbus_hold_port #(.MEM_AW(MEM_AW)) u_hold (
    .clk         (clk),
    .rst         (rst),
    .en_i        (hold_ack_o),
    .bs_n_i      (bs_n_i),
    .sid_i       (sid_i),
    .wr_i        (wr_i),
    .bc_n_i      (bc_n_i),
    .addr_i      (addr_i[MEM_AW-1:0]),
    .data_i      (data_i),
    .mem_rdata_i (mem_rdata_i),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_be_o    (mem_be_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .rd_drive_o  (hp_drive),
    .rd_data_o   (hp_data)
  );

  assign data_o    = hold_ack_o ? hp_data  : wdat_q;
  assign data_oe_o = hold_ack_o ? hp_drive : wroe_q;
endmodule

// File: rtl/xbus_cycle_unit_chk.sv
module xbus_cycle_unit_chk (
  input logic clk,
  input logic rst,
  input logic ready_i,
  input logic hold_ack_o,
  input logic pins_oe_o,
  input logic bs_n_o,
  input logic wr_o,
  input logic [1:0] bc_n_o,
  input logic data_oe_o,
  input logic bs_n_i,
  input logic sid_i,
  input logic mem_req_o
);
  assert_bs_one_cycle_R2: assert property (@(posedge clk) disable iff (rst)
    (!bs_n_o && !ready_i) |=> bs_n_o);

  assert_read_both_lanes_R4: assert property (@(posedge clk) disable iff (rst)
    (!bs_n_o && !wr_o) |-> (bc_n_o == 2'b00));

  assert_released_in_hold_R8: assert property (@(posedge clk) disable iff (rst)
    hold_ack_o |-> !pins_oe_o);

  assert_ack_after_release_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(hold_ack_o) |-> $past(!pins_oe_o));

  assert_drive_after_ack_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(pins_oe_o) |-> (!hold_ack_o && $past(!hold_ack_o)));

  assert_io_space_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    (hold_ack_o && !bs_n_i && sid_i) |=> !mem_req_o);

  assert_data_only_writes_R12: assert property (@(posedge clk) disable iff (rst)
    (data_oe_o && !hold_ack_o) |-> wr_o);
endmodule

bind xbus_cycle_unit xbus_cycle_unit_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .ready_i    (ready_i),
  .hold_ack_o (hold_ack_o),
  .pins_oe_o  (pins_oe_o),
  .bs_n_o     (bs_n_o),
  .wr_o       (wr_o),
  .bc_n_o     (bc_n_o),
  .data_oe_o  (data_oe_o),
  .bs_n_i     (bs_n_i),
  .sid_i      (sid_i),
  .mem_req_o  (mem_req_o)
);

// File: tb/xbus_cycle_unit_tb.sv
`timescale 1ns/1ps
module xbus_cycle_unit_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic        req_valid_i = 0, req_write_i = 0, req_fetch_i = 0, req_io_i = 0;
  logic [1:0]  req_size_i = 0;
  logic [23:0] req_addr_i = 0;
  logic [31:0] req_wdata_i = 0;
  logic        ready_i = 0, hold_req_i = 0;
  logic [22:0] addr_i = 0;
  logic [1:0]  bc_n_i = 2'b11;
  logic        sid_i = 0, bs_n_i = 1, wr_i = 0;
  logic [15:0] data_i = 0;
  logic [15:0] mem_rdata_i = 0;
  logic        req_ready_o, rsp_valid_o, hold_ack_o, pins_oe_o, sid_o, bs_n_o, st_o, wr_o;
  logic        data_oe_o, mem_req_o, mem_we_o;
  logic [31:0] rsp_data_o;
  logic [22:0] addr_o;
  logic [1:0]  bc_n_o, mem_be_o;
  logic [15:0] data_o, mem_wdata_o;
  logic [18:0] mem_addr_o;

  xbus_cycle_unit dut_i (.*);

  // synchronous on-chip memory model: read data one cycle after request
  always @(posedge clk)
    if (mem_req_o && !mem_we_o) mem_rdata_i <= mem_addr_o[15:0] ^ 16'h5A3C;

  int nchk = 0, nfail = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  typedef struct packed {
    logic [1:0]  sz;
    logic        wr;
    logic        fe;
    logic        io;
    logic [23:0] ad;
    logic [31:0] wd;
    logic [31:0] sd;
    logic [1:0]  wt;
    logic [31:0] ex;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b0, 1'b0, 1'b0, 24'h001234, 32'h0, 32'hAB12_0000, 2'd0, 32'h0000_00AB},
    '{2'd0, 1'b0, 1'b0, 1'b1, 24'h001235, 32'h0, 32'hAB12_0000, 2'd1, 32'h0000_0012},
    '{2'd1, 1'b0, 1'b1, 1'b0, 24'h002000, 32'h0, 32'hC0DE_0000, 2'd0, 32'h0000_C0DE},
    '{2'd2, 1'b0, 1'b1, 1'b0, 24'h00300A, 32'h0, 32'h1234_5678, 2'd2, 32'h1234_5678},
    '{2'd0, 1'b1, 1'b0, 1'b0, 24'h004001, 32'h0000_005A, 32'h0, 2'd0, 32'h0},
    '{2'd1, 1'b1, 1'b0, 1'b1, 24'h004002, 32'h0000_BEEF, 32'h0, 2'd1, 32'h0},
    '{2'd2, 1'b1, 1'b0, 1'b0, 24'h005004, 32'hCAFE_F00D, 32'h0, 2'd0, 32'h0},
    '{2'd3, 1'b0, 1'b1, 1'b0, 24'h006000, 32'h0, 32'h89AB_CDEF, 2'd1, 32'h89AB_CDEF},
    '{2'd0, 1'b1, 1'b0, 1'b0, 24'h004000, 32'h0000_0077, 32'h0, 2'd0, 32'h0}
  };

  function automatic int beats_of(input logic [1:0] sz);
    return (sz == 2'd2) ? 2 : (sz == 2'd3) ? 4 : 1;
  endfunction

  function automatic logic [15:0] slave_beat(input vec_t v, input int b);
    logic [31:0] w;
    w = (b >= 2) ? ~v.sd : v.sd;
    return b[0] ? w[15:0] : w[31:16];
  endfunction

  task automatic run_vec(input vec_t v);
    int nb;
    logic [22:0] base;
    logic [31:0] word_exp;
    nb   = beats_of(v.sz);
    base = v.sz[1] ? {v.ad[23:2], 1'b0} : v.ad[23:1];
    @(negedge clk);
    req_valid_i = 1; req_write_i = v.wr; req_fetch_i = v.fe; req_io_i = v.io;
    req_size_i = v.sz; req_addr_i = v.ad; req_wdata_i = v.wd;
    chk("R1 ready before access", {31'd0, req_ready_o}, 32'd1);
    @(negedge clk);
    req_valid_i = 0;
    for (int b = 0; b < nb; b++) begin
      chk("R2 start strobe low", {31'd0, bs_n_o}, 32'd0);
      chk("R3 halfword address", {9'd0, addr_o}, {9'd0, base + 23'(b)});
      chk("R4 byte strobes", {30'd0, bc_n_o},
          (v.wr && v.sz == 2'd0) ? (v.ad[0] ? 32'd2 : 32'd1) : 32'd0);
      chk("R6 status line", {31'd0, st_o}, {31'd0, !v.fe});
      chk("R6 space select", {31'd0, sid_o}, {31'd0, v.io});
      chk("R12 write indicator", {31'd0, wr_o}, {31'd0, v.wr});
      chk("R12 data drive", {31'd0, data_oe_o}, {31'd0, v.wr});
      if (v.wr) begin
        if (v.sz == 2'd0)      chk("R12 byte data", {16'd0, data_o}, {16'd0, v.wd[7:0], v.wd[7:0]});
        else if (v.sz == 2'd1) chk("R12 half data", {16'd0, data_o}, {16'd0, v.wd[15:0]});
        else chk("R12 word data order", {16'd0, data_o}, {16'd0, b[0] ? v.wd[15:0] : v.wd[31:16]});
      end
      for (int w = 0; w < int'(v.wt); w++) begin
        @(negedge clk);
        chk("R2 strobe high while waiting", {31'd0, bs_n_o}, 32'd1);
        chk("R5 no early response", {31'd0, rsp_valid_o}, 32'd0);
      end
      ready_i = 1; data_i = slave_beat(v, b);
      @(negedge clk);
      ready_i = 0;
      if (!v.sz[1] || b[0]) begin
        chk("R5 response pulse", {31'd0, rsp_valid_o}, 32'd1);
        if (!v.wr) begin
          word_exp = (b >= 2) ? ~v.ex : v.ex;
          chk("R5 read data", rsp_data_o, word_exp);
        end
      end else begin
        chk("R5 no response mid word", {31'd0, rsp_valid_o}, 32'd0);
      end
    end
    chk("R2 strobe idle after access", {31'd0, bs_n_o}, 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 start strobe", {31'd0, bs_n_o}, 32'd1);
    chk("R1 pins driven", {31'd0, pins_oe_o}, 32'd1);
    chk("R1 hold ack", {31'd0, hold_ack_o}, 32'd0);
    chk("R1 data drive", {31'd0, data_oe_o}, 32'd0);
    chk("R1 response", {31'd0, rsp_valid_o}, 32'd0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R7 on-chip region: accepted, no external cycle
    @(negedge clk);
    req_valid_i = 1; req_write_i = 0; req_size_i = 2'd2; req_addr_i = 24'hF01000;
    chk("R7 accepted", {31'd0, req_ready_o}, 32'd1);
    @(negedge clk);
    req_valid_i = 0;
    for (int k = 0; k < 3; k++) begin
      chk("R7 no start strobe", {31'd0, bs_n_o}, 32'd1);
      chk("R7 no response", {31'd0, rsp_valid_o}, 32'd0);
      @(negedge clk);
    end

    // R8 hold request raised during a word burst
    req_valid_i = 1; req_write_i = 0; req_fetch_i = 0; req_io_i = 0;
    req_size_i = 2'd2; req_addr_i = 24'h007000;
    @(negedge clk);
    req_valid_i = 0; hold_req_i = 1;
    for (int k = 0; k < 2; k++) begin
      chk("R8 no ack during burst", {31'd0, hold_ack_o}, 32'd0);
      chk("R8 pins driven during burst", {31'd0, pins_oe_o}, 32'd1);
      @(negedge clk);
    end
    ready_i = 1; data_i = 16'h1111;
    @(negedge clk);
    chk("R2 second beat strobe", {31'd0, bs_n_o}, 32'd0);
    chk("R8 no ack before last beat", {31'd0, hold_ack_o}, 32'd0);
    data_i = 16'h2222;
    @(negedge clk);
    ready_i = 0;
    chk("R5 burst completes under hold request", rsp_data_o, 32'h1111_2222);
    chk("R8 pins still driven", {31'd0, pins_oe_o}, 32'd1);
    @(negedge clk);
    chk("R8 pins released", {31'd0, pins_oe_o}, 32'd0);
    chk("R8 ack waits for release", {31'd0, hold_ack_o}, 32'd0);
    @(negedge clk);
    chk("R8 ack raised", {31'd0, hold_ack_o}, 32'd1);
    chk("R8 pins released in hold", {31'd0, pins_oe_o}, 32'd0);
    chk("R8 core blocked", {31'd0, req_ready_o}, 32'd0);

    // R10 external master write, top address bits ignored
    bs_n_i = 0; sid_i = 0; wr_i = 1; bc_n_i = 2'b01;
    addr_i = {4'hB, 19'h01234}; data_i = 16'hBEEF;
    @(negedge clk);
    bs_n_i = 1;
    chk("R10 memory request", {31'd0, mem_req_o}, 32'd1);
    chk("R10 write", {31'd0, mem_we_o}, 32'd1);
    chk("R10 byte enables", {30'd0, mem_be_o}, 32'd2);
    chk("R10 address top bits ignored", {13'd0, mem_addr_o}, 32'h01234);
    chk("R10 write data", {16'd0, mem_wdata_o}, 32'h0000BEEF);

    // R10 I/O space selected: ignored
    @(negedge clk);
    bs_n_i = 0; sid_i = 1; wr_i = 1;
    @(negedge clk);
    bs_n_i = 1; sid_i = 0;
    chk("R10 io space no request", {31'd0, mem_req_o}, 32'd0);

    // R11 external master read
    @(negedge clk);
    bs_n_i = 0; wr_i = 0; bc_n_i = 2'b00; addr_i = {4'h3, 19'h00456};
    @(negedge clk);
    bs_n_i = 1;
    chk("R11 read request", {31'd0, mem_req_o}, 32'd1);
    @(negedge clk);
    chk("R11 not yet driven", {31'd0, data_oe_o}, 32'd0);
    @(negedge clk);
    chk("R11 data driven", {31'd0, data_oe_o}, 32'd1);
    chk("R11 read data", {16'd0, data_o}, {16'd0, 16'h0456 ^ 16'h5A3C});
    @(negedge clk);
    chk("R11 drive one cycle", {31'd0, data_oe_o}, 32'd0);

    // R9 release
    hold_req_i = 0;
    @(negedge clk);
    chk("R9 ack dropped", {31'd0, hold_ack_o}, 32'd0);
    chk("R9 pins still released", {31'd0, pins_oe_o}, 32'd0);
    @(negedge clk);
    chk("R9 pins driven again", {31'd0, pins_oe_o}, 32'd1);
    chk("R9 core accepted again", {31'd0, req_ready_o}, 32'd1);

    // one more access after hold
    run_vec(VECS[3]);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule